// File: doc/BRIEF.md
# GPIO Port with Control Register Bank

This peripheral sits on a 16-bit register port. It decodes word-aligned byte offsets inside a 4 KB window. Behind the decoder are seven plain 16-bit control registers, one read-only status register, and a 16-line general-purpose output port. A direction register enables each line. A level register holds the value each line should drive. The level seen on a line is the level bit ANDed with its direction bit.

After every bus write to the direction or level register, the block compares the new effective output with the value it last drove. Each line that differs gets a one-cycle change strobe, and that line's driven level is updated. External input events can set or clear individual level bits at any time. These events do not start a comparison on their own. A later direction or level write picks up whatever level they left.

The register port has no back-pressure. A request is taken in the cycle in which `sel` is high, and the block never stalls the bus. Read data is registered and appears in the cycle after the request. The input-event lines are plain strobes. Nothing here carries a stream, so none of the ports use valid/ready.

Top module: `gcr_top`

## Requirements
- R1: After reset the status register at offset 0x08 reads 0x0002. Every other register reads 0x0000, and `gpio_out` and `gpio_chg` are zero.
- R2: A read request (`sel`=1, `wr_en`=0) puts the addressed value on `rdata` in the following cycle. In any cycle that follows a non-read cycle, `rdata` is 0x0000.
- R3: Writes to offsets 0x00, 0x04, 0x10, 0x14, 0x18, 0x1C and 0x20 store the full 16-bit value, and a read of the same offset returns it.
- R4: A write to offset 0x0C stores the value. If bit 7 of the written value is 1, bits 15 and 6 are also stored as 1.
- R5: Offset 0x08 is read-only, and a write to it leaves it reading 0x0002.
- R6: Unmapped offsets return 0x0000 on a read, and writes to them change no register and no output. This covers offsets above 0x28 and any offset with bit 1 or bit 0 set.
- R7: A write to offset 0x24 or 0x28 stores the written value ANDed with the current direction register (offset 0x20). A read of either offset returns that stored level.
- R8: In the cycle after a direction or level write, `gpio_chg[n]` is 1 exactly for the lines where (level AND direction) differs from the current `gpio_out[n]`, and `gpio_out` takes the new (level AND direction). In all other cycles `gpio_chg` is zero and `gpio_out` holds its value.
- R9: When `gpio_in_evt[n]` is 1, level bit n takes `gpio_in_val[n]`, whatever the direction bit is. This alone produces no strobe and does not change `gpio_out`.
- R10: When a bus level write and input events fall in the same cycle, the bus write sets the whole level register and the events are lost.
- R11: A direction write compares outputs using the level as modified by earlier input events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register access request this cycle |
| wr_en | input | 1 | 1 = write, 0 = read (with `sel`) |
| addr | input | 12 | Byte offset within the window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| gpio_in_evt | input | 16 | Per-line input event strobe |
| gpio_in_val | input | 16 | Per-line input value applied on event |
| gpio_out | output | 16 | Driven level of each line |
| gpio_chg | output | 16 | One-cycle per-line change strobe |

## Verification
Every result is due one rising edge after its stimulus:
- Read data appears in the cycle after the read request.
- `gpio_out` and the `gpio_chg` strobe appear in the cycle after the direction or level write that caused them.
- The strobe has cleared one cycle after that.

The bench drives each request on a falling edge and removes it on the next falling edge. It samples at that same falling edge, which falls halfway through the cycle in which the registered result is held. To show that a pulse lasts exactly one cycle, the bench checks it again one falling edge later. An expected level and driven value are kept in the bench from the requirements alone. Input events are checked by reading the level back over the bus and by confirming that the outputs did not move.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int DATA_W = 16;
  localparam int BANK_REGS = 8;
  localparam int LAST_WORD = 10;
  localparam logic [15:0] STAT_RESET = 16'h0002;
  localparam int PWR_TRIGGER_BIT = 7;
  localparam logic [15:0] PWR_FORCE_MASK = 16'h8040;

  // word index order is fixed by the register offsets
  typedef enum logic [3:0] {
    RG_MODE    = 4'd0,
    RG_DETECT  = 4'd1,
    RG_STAT    = 4'd2,
    RG_PWR     = 4'd3,
    RG_CARDCTL = 4'd4,
    RG_IRQREQ  = 4'd5,
    RG_IRQMSK  = 4'd6,
    RG_IRQSTS  = 4'd7,
    RG_DIR     = 4'd8,
    RG_LVL     = 4'd9,
    RG_NONE    = 4'd15
  } reg_id_e;
endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] addr,
  output reg_id_e       id
);
  localparam int IW = AW - 2;

  logic [IW-1:0] widx;
  assign widx = addr[AW-1:2];

  always_comb begin
    id = RG_NONE;
    if (addr[1:0] == 2'b00) begin
      if (widx < IW'(BANK_REGS + 1))
        id = reg_id_e'(widx[3:0]);
      else if (widx <= IW'(LAST_WORD))
        id = RG_LVL;
    end
  end
endmodule

// File: rtl/gcr_ctrl_bank.sv
module gcr_ctrl_bank
  import gcr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  reg_id_e       id,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val
);
  logic [DW-1:0] store [BANK_REGS];

  for (genvar g = 0; g < BANK_REGS; g++) begin : g_reg
    if (g == int'(RG_STAT)) begin : g_ro
      assign store[g] = DW'(STAT_RESET);
    end else begin : g_rw
      logic          hit;
      logic [DW-1:0] nxt;
      logic [DW-1:0] q;
      assign hit = we && (id == reg_id_e'(g));
      if (g == int'(RG_PWR)) begin : g_pwr
        assign nxt = wdata[PWR_TRIGGER_BIT] ? (wdata | DW'(PWR_FORCE_MASK)) : wdata;
      end else begin : g_plain
        assign nxt = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= nxt;
      end
      assign store[g] = q;
    end
  end

  always_comb begin
    rd_val = '0;
    if (id < RG_DIR) rd_val = store[id[2:0]];
  end

  // R4: bit 7 written forces bits 15 and 6
  a_r4_power_force: assert property (@(posedge clk) disable iff (!rst_n)
    (we && id == RG_PWR && wdata[PWR_TRIGGER_BIT]) |=>
      ((store[int'(RG_PWR)] & DW'(PWR_FORCE_MASK)) == DW'(PWR_FORCE_MASK)));
endmodule

// File: rtl/gcr_gpio_port.sv
module gcr_gpio_port #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_dir,
  input  logic         we_lvl,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] in_evt,
  input  logic [N-1:0] in_val,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] gpio_out,
  output logic [N-1:0] gpio_chg
);
  logic [N-1:0] dir_nx, lvl_nx, eff_nx;
  logic         eval;

  assign eval   = we_dir || we_lvl;
  assign dir_nx = we_dir ? wdata : dir_q;

  // bus level write wins over same-cycle input events
  for (genvar g = 0; g < N; g++) begin : g_line
    assign lvl_nx[g] = we_lvl    ? (wdata[g] & dir_q[g]) :
                       in_evt[g] ? in_val[g] : lvl_q[g];
  end

  assign eff_nx = lvl_nx & dir_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      lvl_q    <= '0;
      gpio_out <= '0;
      gpio_chg <= '0;
    end else begin
      dir_q <= dir_nx;
      lvl_q <= lvl_nx;
      if (eval) begin
        gpio_out <= eff_nx;
        gpio_chg <= eff_nx ^ gpio_out;
      end else begin
        gpio_chg <= '0;
      end
    end
  end

  // R8: driven value moves exactly on strobed lines
  a_r8_out_tracks_chg: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gpio_out ^ $past(gpio_out)) == gpio_chg));
  // R8: nothing is driven on a line whose direction bit is clear
  a_r8_out_within_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_out & ~dir_q) == '0);
  // R7: level written by the bus is masked by direction
  a_r7_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
    we_lvl |=> ((lvl_q & ~$past(dir_q)) == '0));
  // R9: no strobe without a direction or level write
  a_r9_no_spurious_chg: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> (gpio_chg == '0));
endmodule

// File: rtl/gcr_top.sv
module gcr_top
  import gcr_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = 12,
  parameter int NGPIO = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NGPIO-1:0] gpio_in_evt,
  input  logic [NGPIO-1:0] gpio_in_val,
  output logic [NGPIO-1:0] gpio_out,
  output logic [NGPIO-1:0] gpio_chg
);
  reg_id_e          id;
  logic             bus_we, bus_rd;
  logic [DW-1:0]    bank_rd, rd_mux;
  logic [NGPIO-1:0] dir_q, lvl_q;

  assign bus_we = sel && wr_en;
  assign bus_rd = sel && !wr_en;

  gcr_decode #(.AW(AW)) u_dec (
    .addr (addr),
    .id   (id)
  );

  gcr_ctrl_bank #(.DW(DW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bus_we),
    .id     (id),
    .wdata  (wdata),
    .rd_val (bank_rd)
  );

  gcr_gpio_port #(.N(NGPIO)) u_gpio (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_dir   (bus_we && id == RG_DIR),
    .we_lvl   (bus_we && id == RG_LVL),
    .wdata    (wdata[NGPIO-1:0]),
    .in_evt   (gpio_in_evt),
    .in_val   (gpio_in_val),
    .dir_q    (dir_q),
    .lvl_q    (lvl_q),
    .gpio_out (gpio_out),
    .gpio_chg (gpio_chg)
  );

  always_comb begin
    rd_mux = '0;
    case (id)
      RG_DIR:  rd_mux[NGPIO-1:0] = dir_q;
      RG_LVL:  rd_mux[NGPIO-1:0] = lvl_q;
      RG_NONE: rd_mux = '0;
      default: rd_mux = bank_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (bus_rd) rdata <= rd_mux;
    else             rdata <= '0;
  end

  // R2: no read request, no read data
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (rdata == '0));
  // R6: unmapped offsets read as zero
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && id == RG_NONE) |=> (rdata == '0));
  // R5: status always reads its fixed value
  a_r5_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && id == RG_STAT) |=> (rdata == DW'(STAT_RESET)));
endmodule

// File: tb/gcr_top_test.sv
module gcr_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] gpio_in_evt = '0, gpio_in_val = '0;
  logic [15:0] gpio_out, gpio_chg;

  int checks = 0, failures = 0;
  logic [15:0] m_dir = '0, m_lvl = '0, m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcr_top uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gpio_in_evt(gpio_in_evt),
    .gpio_in_val(gpio_in_val), .gpio_out(gpio_out), .gpio_chg(gpio_chg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk); sel = 1'b1; wr_en = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; v = rdata;
  endtask

  // model of a direction or level write, then check strobe and output
  task automatic gpio_write(input string req, input logic [11:0] a, input logic [15:0] d);
    logic [15:0] eff;
    bwrite(a, d);
    if (a == 12'h020) m_dir = d; else m_lvl = d & m_dir;
    eff = m_lvl & m_dir;
    check({req, " strobe"}, gpio_chg, eff ^ m_out);
    m_out = eff;
    check({req, " out"}, gpio_out, m_out);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 out", gpio_out, 16'h0000);
    check("R1 chg", gpio_chg, 16'h0000);
    for (int i = 0; i <= 10; i++) begin
      bread(12'(i * 4), v);
      check($sformatf("R1 reg %0d", i), v, (i == 2) ? 16'h0002 : 16'h0000);
    end
  endtask

  task automatic t_plain_regs();
    logic [15:0] v;
    logic [11:0] offs [6] = '{12'h000, 12'h004, 12'h010, 12'h014, 12'h018, 12'h01C};
    for (int i = 0; i < 6; i++) bwrite(offs[i], 16'hA500 + 16'(i * 17));
    for (int i = 0; i < 6; i++) begin
      bread(offs[i], v);
      check($sformatf("R3 off %03h", offs[i]), v, 16'hA500 + 16'(i * 17));
    end
    @(negedge clk);
    check("R2 idle rdata", rdata, 16'h0000);
  endtask

  task automatic t_power();
    logic [15:0] v;
    bwrite(12'h00C, 16'h0080); bread(12'h00C, v); check("R4 bit7 only", v, 16'h80C0);
    bwrite(12'h00C, 16'h0005); bread(12'h00C, v); check("R4 bit7 clear", v, 16'h0005);
    bwrite(12'h00C, 16'h12B4); bread(12'h00C, v); check("R4 mixed", v, 16'h92F4);
  endtask

  task automatic t_status_ro();
    logic [15:0] v;
    bwrite(12'h008, 16'hFFFF); bread(12'h008, v); check("R5 status", v, 16'h0002);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    bwrite(12'h002, 16'hFFFF);
    bwrite(12'h022, 16'hFFFF);
    check("R6 no strobe", gpio_chg, 16'h0000);
    bwrite(12'h02C, 16'hFFFF);
    bwrite(12'hFFC, 16'hFFFF);
    bread(12'h02C, v); check("R6 read 02C", v, 16'h0000);
    bread(12'h001, v); check("R6 read 001", v, 16'h0000);
    bread(12'h000, v); check("R6 mode kept", v, 16'hA500);
    bread(12'h020, v); check("R6 dir kept", v, 16'h0000);
    check("R6 out kept", gpio_out, 16'h0000);
  endtask

  task automatic t_level_change();
    logic [15:0] v;
    gpio_write("R8 dir first", 12'h020, 16'h00FF);
    gpio_write("R8 lvl write", 12'h024, 16'hFFFF);
    @(negedge clk);
    check("R8 pulse one cycle", gpio_chg, 16'h0000);
    bread(12'h024, v); check("R7 read 024", v, 16'h00FF);
    bread(12'h028, v); check("R7 read 028", v, 16'h00FF);
    bread(12'h020, v); check("R3 dir readback", v, 16'h00FF);
    gpio_write("R8 dir narrow", 12'h020, 16'h0F0F);
    gpio_write("R7 lvl via 028", 12'h028, 16'h00FF);
    bread(12'h024, v); check("R7 masked store", v, m_lvl);
  endtask

  task automatic t_inputs();
    logic [15:0] v;
    logic [15:0] ev [3] = '{16'h0100, 16'h0001, 16'h1000};
    logic [15:0] vl [3] = '{16'h0100, 16'h0000, 16'h1000};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); gpio_in_evt = ev[i]; gpio_in_val = vl[i];
      @(negedge clk); gpio_in_evt = '0; gpio_in_val = '0;
      m_lvl = (m_lvl & ~ev[i]) | vl[i];
      check("R9 no strobe", gpio_chg, 16'h0000);
      check("R9 out held", gpio_out, m_out);
    end
    bread(12'h024, v); check("R9 level bits", v, m_lvl);
    gpio_write("R11 dir reeval", 12'h020, 16'h1F0F);
  endtask

  task automatic t_collision();
    logic [15:0] v, eff;
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; addr = 12'h024; wdata = 16'h0003;
    gpio_in_evt = 16'h0120; gpio_in_val = 16'h0120;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; gpio_in_evt = '0; gpio_in_val = '0;
    m_lvl = 16'h0003 & m_dir;
    eff = m_lvl & m_dir;
    check("R10 strobe", gpio_chg, eff ^ m_out);
    m_out = eff;
    check("R10 out", gpio_out, m_out);
    bread(12'h024, v); check("R10 level", v, m_lvl);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_regs();
    t_power();
    t_status_ro();
    t_unmapped();
    t_level_change();
    t_inputs();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule